// File: doc/BRIEF.md
# Sensor Protocol Phase Sequencer

This block paces the transmit side of a sensor's serial protocol. It produces a one-cycle strobe at the start of every message slot, and it steps the protocol through its start-up phases. After reset the sequencer waits through a fixed power-on initialization period. It then sends device data for a number of slots that depends on a 2-bit mode field. Next comes an optional self-test phase, then an auto-zero initialization phase. Normal operation follows, and only reset leaves it.

Slots come from one of two sources. In asynchronous mode an internal divider on the master clock makes the slots. The slot is twice as long during device data in mode 0. In synchronous mode every rising edge of an external sync pulse makes one slot. The sync pulse first passes a short synchronizer. During self-test the block also reports which self-test cycle and which interval inside that cycle are running. The frame encoder uses these indices. Every duration is a parameter. The defaults give a 100,000-clock initialization, slots of 228 or 456 clocks, device-data lengths of 9, 480 or 512 slots, self-test cycles of 3 intervals of 96 slots repeated 6 times, and 65,535 auto-zero slots.

Top module: `proto_phase_seq`

## Requirements
- R1: While reset is asserted, `phase_o` is 0, `slot_strobe_o` is low and both self-test indices are 0.
- R2: The initialization phase (code 0) lasts exactly INIT_CLKS clock cycles in both slot modes. During it `slot_strobe_o` stays low and sync pulses have no effect.
- R3: In asynchronous mode (`sync_mode_i` = 0) the strobe is high for one cycle in every SLOT_CLKS cycles. During device data with latched mode 0 the spacing is SLOT_CLKS_LONG. The first strobe of a phase falls in the last cycle of its first slot. `sync_pulse_i` is ignored in this mode.
- R4: In synchronous mode (`sync_mode_i` = 1) each low-to-high change of `sync_pulse_i`, as seen at clock edges, gives exactly one strobe cycle. Count the first edge that samples the pulse high as edge 1. The strobe is then high in the cycle after edge SYNC_STAGES. A pulse held high gives no more strobes.
- R5: Device data (code 1) lasts DATA_SLOTS_M0 slots for mode value 0, DATA_SLOTS_M12 slots for mode values 1 and 2, and DATA_SLOTS_M3 slots for mode value 3.
- R6: `mode_i` is captured on the clock edge that ends initialization. Later changes to `mode_i` do not alter the length of the device-data phase or its slot period.
- R7: If `selftest_en_i` is high on the edge that ends device data, self-test (code 2) follows and lasts ST_CYCLES × ST_INTERVALS × ST_INTERVAL_SLOTS slots. Otherwise the sequencer goes straight to auto-zero (code 3).
- R8: In self-test, `st_interval_o` counts intervals of ST_INTERVAL_SLOTS slots, from 0 to ST_INTERVALS-1. `st_cycle_o` counts completed interval groups, from 0 to ST_CYCLES-1. Outside self-test both are 0.
- R9: Auto-zero (code 3) lasts AZ_SLOTS slots and is followed by normal operation (code 4).
- R10: Normal operation is terminal. It never changes until reset, and its strobes keep the base slot spacing.
- R11: A phase other than initialization ends on the clock edge that closes the cycle carrying its final strobe. The only transitions are 0→1, 1→2, 1→3, 2→3 and 3→4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_mode_i | input | 1 | 1 selects sync-pulse slots, 0 the internal divider |
| sync_pulse_i | input | 1 | External slot sync pulse |
| mode_i | input | 2 | Data mode field, captured when device data starts |
| selftest_en_i | input | 1 | Runs the self-test phase when high at the end of device data |
| phase_o | output | 3 | Current phase code (0..4) |
| slot_strobe_o | output | 1 | One-cycle message-slot strobe |
| st_cycle_o | output | $clog2(ST_CYCLES+1) | Self-test cycle index |
| st_interval_o | output | $clog2(ST_INTERVALS+1) | Interval index inside the self-test cycle |

## Verification
The assertions assume that `sync_mode_i` changes only while reset is held, because the divider and the edge detector do not hand over mid-phase. The stimulus changes it only under reset. They also assume that the divider period is at least two clocks, so two async strobes can never fall in adjacent cycles. Scaled parameters keep this true. The sync pulse may have any width and spacing. The stimulus uses both narrow pulses and long-held ones, and it sends pulses during initialization and in asynchronous runs to show that they are ignored. `mode_i` is changed in the last initialization cycle and in the middle of device data to test the capture point.

// File: rtl/proto_seq_pkg.sv
package proto_seq_pkg;

   typedef enum logic [2:0] {
      PH_INIT     = 3'd0,
      PH_DATA     = 3'd1,
      PH_SELFTEST = 3'd2,
      PH_AUTOZERO = 3'd3,
      PH_NORMAL   = 3'd4
   } phase_e;

   localparam int unsigned MODE_W = 2;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned width_for(input int unsigned count);
      return (count > 1) ? $clog2(count) : 1;
   endfunction

endpackage

// File: rtl/proto_seq_slot_src.sv
module proto_seq_slot_src
   import proto_seq_pkg::*;
#(
   parameter int unsigned SLOT_CLKS      = 228,
   parameter int unsigned SLOT_CLKS_LONG = 456,
   parameter int unsigned SYNC_STAGES    = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic sync_mode_i,
   input  logic sync_i,
   input  logic long_i,
   output logic tick_o
);

   localparam int unsigned DIV_W = width_for(max_u(SLOT_CLKS, SLOT_CLKS_LONG));

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] div_last;
   logic             async_hit;

   generate
      if (SLOT_CLKS_LONG == SLOT_CLKS) begin : g_one_period
         assign div_last = DIV_W'(SLOT_CLKS - 1);
      end else begin : g_two_periods
         assign div_last = long_i ? DIV_W'(SLOT_CLKS_LONG - 1) : DIV_W'(SLOT_CLKS - 1);
      end
   endgenerate

   assign async_hit = run_i && !sync_mode_i && (div_q == div_last);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         div_q <= '0;
      end else if (!run_i || sync_mode_i || async_hit) begin
         div_q <= '0;
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

   logic [SYNC_STAGES-1:0] chain_q;
   logic                   prev_q;
   logic                   sync_rise;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q[0] <= sync_i;
         for (int i = 1; i < int'(SYNC_STAGES); i++) begin
            chain_q[i] <= chain_q[i-1];
         end
         prev_q <= chain_q[SYNC_STAGES-1];
      end
   end

   assign sync_rise = chain_q[SYNC_STAGES-1] && !prev_q;
   assign tick_o    = async_hit || (run_i && sync_mode_i && sync_rise);

   // R3: the divider never runs past the active period
   assert_div_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && !sync_mode_i) |-> (div_q <= div_last));

   // R3: async strobes never fall in adjacent cycles
   assert_async_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_o && !sync_mode_i) |=> !tick_o);

   // R4: one strobe per rising edge, so never two in a row
   assert_sync_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_o && sync_mode_i) |=> !tick_o);

endmodule

// File: rtl/proto_seq_phase_fsm.sv
module proto_seq_phase_fsm
   import proto_seq_pkg::*;
#(
   parameter int unsigned INIT_CLKS      = 100000,
   parameter int unsigned DATA_SLOTS_M0  = 9,
   parameter int unsigned DATA_SLOTS_M12 = 480,
   parameter int unsigned DATA_SLOTS_M3  = 512,
   parameter int unsigned ST_SLOTS       = 1728,
   parameter int unsigned AZ_SLOTS       = 65535
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic [MODE_W-1:0] mode_i,
   input  logic              st_en_i,
   output phase_e            phase_o,
   output logic              long_slot_o
);

   localparam int unsigned MAX_LEN = max_u(max_u(DATA_SLOTS_M0, DATA_SLOTS_M12),
                                           max_u(DATA_SLOTS_M3, max_u(ST_SLOTS, AZ_SLOTS)));
   localparam int unsigned CNT_W   = width_for(MAX_LEN);
   localparam int unsigned INIT_W  = width_for(INIT_CLKS);

   phase_e              phase_q, phase_d;
   logic [INIT_W-1:0]   init_q;
   logic [CNT_W-1:0]    slot_q;
   logic [CNT_W-1:0]    cur_last;
   logic [MODE_W-1:0]   mode_q;
   logic                init_done;
   logic                counted;
   logic                seg_done;

   always_comb begin
      unique case (phase_q)
         PH_DATA: begin
            unique case (mode_q)
               2'd0:    cur_last = CNT_W'(DATA_SLOTS_M0 - 1);
               2'd3:    cur_last = CNT_W'(DATA_SLOTS_M3 - 1);
               default: cur_last = CNT_W'(DATA_SLOTS_M12 - 1);
            endcase
         end
         PH_SELFTEST: cur_last = CNT_W'(ST_SLOTS - 1);
         PH_AUTOZERO: cur_last = CNT_W'(AZ_SLOTS - 1);
         default:     cur_last = '0;
      endcase
   end

   assign init_done = (phase_q == PH_INIT) && (init_q == INIT_W'(INIT_CLKS - 1));
   assign counted   = (phase_q == PH_DATA) || (phase_q == PH_SELFTEST) || (phase_q == PH_AUTOZERO);
   assign seg_done  = counted && tick_i && (slot_q == cur_last);

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_INIT:     if (init_done) phase_d = PH_DATA;
         PH_DATA:     if (seg_done)  phase_d = st_en_i ? PH_SELFTEST : PH_AUTOZERO;
         PH_SELFTEST: if (seg_done)  phase_d = PH_AUTOZERO;
         PH_AUTOZERO: if (seg_done)  phase_d = PH_NORMAL;
         default:                    phase_d = PH_NORMAL;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= PH_INIT;
         init_q  <= '0;
         slot_q  <= '0;
         mode_q  <= '0;
      end else begin
         phase_q <= phase_d;
         if ((phase_q == PH_INIT) && !init_done) begin
            init_q <= init_q + 1'b1;
         end
         if (init_done) begin
            mode_q <= mode_i;
         end
         if (!counted || seg_done) begin
            slot_q <= '0;
         end else if (tick_i) begin
            slot_q <= slot_q + 1'b1;
         end
      end
   end

   assign phase_o     = phase_q;
   assign long_slot_o = (phase_q == PH_DATA) && (mode_q == 2'd0);

   // R11: only the listed successor phases are reachable
   assert_phase_step_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_q != $past(phase_q)) |->
         (($past(phase_q) == PH_INIT     && phase_q == PH_DATA) ||
          ($past(phase_q) == PH_DATA     && (phase_q == PH_SELFTEST || phase_q == PH_AUTOZERO)) ||
          ($past(phase_q) == PH_SELFTEST && phase_q == PH_AUTOZERO) ||
          ($past(phase_q) == PH_AUTOZERO && phase_q == PH_NORMAL)));

   // R11: slot-timed phases end only on a strobe
   assert_step_on_tick_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_q != $past(phase_q) && $past(phase_q) != PH_INIT) |-> $past(tick_i));

   // R2: initialization leaves only after its full clock count
   assert_init_length_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_q == PH_DATA && $past(phase_q) == PH_INIT) |-> ($past(init_q) == INIT_W'(INIT_CLKS - 1)));

   // R10: normal operation is never left
   assert_normal_terminal_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(phase_q) == PH_NORMAL) |-> (phase_q == PH_NORMAL));

   // R6: latched mode stays put for the whole data phase
   assert_mode_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_q == PH_DATA && $past(phase_q) == PH_DATA) |-> $stable(mode_q));

   // R5: the slot counter never passes the phase length
   assert_slot_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      counted |-> (slot_q <= cur_last));

endmodule

// File: rtl/proto_seq_st_index.sv
module proto_seq_st_index
   import proto_seq_pkg::*;
#(
   parameter int unsigned INTERVAL_SLOTS = 96,
   parameter int unsigned INTERVALS      = 3,
   parameter int unsigned CYCLES         = 6
) (
   input  logic                             clk_i,
   input  logic                             rst_ni,
   input  logic                             active_i,
   input  logic                             tick_i,
   output logic [$clog2(CYCLES+1)-1:0]      cycle_o,
   output logic [$clog2(INTERVALS+1)-1:0]   interval_o
);

   localparam int unsigned SW = width_for(INTERVAL_SLOTS);
   localparam int unsigned IW = $clog2(INTERVALS + 1);
   localparam int unsigned CW = $clog2(CYCLES + 1);

   logic          intv_end;
   logic [IW-1:0] interval_q;
   logic [CW-1:0] cycle_q;
   logic          group_end;

   generate
      if (INTERVAL_SLOTS > 1) begin : g_slot_ctr
         logic [SW-1:0] sl_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               sl_q <= '0;
            end else if (!active_i) begin
               sl_q <= '0;
            end else if (tick_i) begin
               sl_q <= (sl_q == SW'(INTERVAL_SLOTS - 1)) ? '0 : sl_q + 1'b1;
            end
         end
         assign intv_end = active_i && tick_i && (sl_q == SW'(INTERVAL_SLOTS - 1));
      end else begin : g_slot_each
         assign intv_end = active_i && tick_i;
      end
   endgenerate

   assign group_end = intv_end && (interval_q == IW'(INTERVALS - 1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         interval_q <= '0;
         cycle_q    <= '0;
      end else if (!active_i) begin
         interval_q <= '0;
         cycle_q    <= '0;
      end else begin
         if (intv_end) begin
            interval_q <= group_end ? '0 : interval_q + 1'b1;
         end
         if (group_end) begin
            cycle_q <= (cycle_q == CW'(CYCLES - 1)) ? '0 : cycle_q + 1'b1;
         end
      end
   end

   assign cycle_o    = cycle_q;
   assign interval_o = interval_q;

   // R8: indices stay inside their ranges
   assert_index_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (interval_q < IW'(INTERVALS)) && (cycle_q < CW'(CYCLES)));

   // R8: indices read zero once self-test is not running
   assert_index_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !active_i |=> (!active_i |-> (cycle_q == '0 && interval_q == '0)));

   // R8: the cycle index only advances within a self-test run
   assert_cycle_monotone_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_i && $past(active_i) && $past(cycle_q) != CW'(CYCLES - 1)) |-> (cycle_q >= $past(cycle_q)));

endmodule

// File: rtl/proto_phase_seq.sv
module proto_phase_seq
   import proto_seq_pkg::*;
#(
   parameter int unsigned INIT_CLKS         = 100000,
   parameter int unsigned SLOT_CLKS         = 228,
   parameter int unsigned SLOT_CLKS_LONG    = 456,
   parameter int unsigned DATA_SLOTS_M0     = 9,
   parameter int unsigned DATA_SLOTS_M12    = 480,
   parameter int unsigned DATA_SLOTS_M3     = 512,
   parameter int unsigned ST_INTERVAL_SLOTS = 96,
   parameter int unsigned ST_INTERVALS      = 3,
   parameter int unsigned ST_CYCLES         = 6,
   parameter int unsigned AZ_SLOTS          = 65535,
   parameter int unsigned SYNC_STAGES       = 2
) (
   input  logic                              clk_i,
   input  logic                              rst_ni,
   input  logic                              sync_mode_i,
   input  logic                              sync_pulse_i,
   input  logic [1:0]                        mode_i,
   input  logic                              selftest_en_i,
   output logic [2:0]                        phase_o,
   output logic                              slot_strobe_o,
   output logic [$clog2(ST_CYCLES+1)-1:0]    st_cycle_o,
   output logic [$clog2(ST_INTERVALS+1)-1:0] st_interval_o
);

   localparam int unsigned ST_SLOTS = ST_INTERVAL_SLOTS * ST_INTERVALS * ST_CYCLES;

   generate
      if (INIT_CLKS < 2)                 begin : g_bad_init  $error("INIT_CLKS must be 2 or more");           end
      if (SLOT_CLKS < 2)                 begin : g_bad_slot  $error("SLOT_CLKS must be 2 or more");           end
      if (SLOT_CLKS_LONG < SLOT_CLKS)    begin : g_bad_long  $error("SLOT_CLKS_LONG below SLOT_CLKS");        end
      if (DATA_SLOTS_M0 < 1 || DATA_SLOTS_M12 < 1 || DATA_SLOTS_M3 < 1)
                                         begin : g_bad_data  $error("data phase lengths must be nonzero");    end
      if (ST_INTERVAL_SLOTS < 1 || ST_INTERVALS < 1 || ST_CYCLES < 1)
                                         begin : g_bad_st    $error("self-test geometry must be nonzero");    end
      if (AZ_SLOTS < 1)                  begin : g_bad_az    $error("AZ_SLOTS must be nonzero");              end
      if (SYNC_STAGES < 1)               begin : g_bad_sync  $error("SYNC_STAGES must be 1 or more");         end
   endgenerate

   phase_e phase;
   logic   tick;
   logic   long_slot;
   logic   run;

   assign run = (phase != PH_INIT);

   proto_seq_slot_src #(
      .SLOT_CLKS      (SLOT_CLKS),
      .SLOT_CLKS_LONG (SLOT_CLKS_LONG),
      .SYNC_STAGES    (SYNC_STAGES)
   ) slot_src_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .run_i       (run),
      .sync_mode_i (sync_mode_i),
      .sync_i      (sync_pulse_i),
      .long_i      (long_slot),
      .tick_o      (tick)
   );

   proto_seq_phase_fsm #(
      .INIT_CLKS      (INIT_CLKS),
      .DATA_SLOTS_M0  (DATA_SLOTS_M0),
      .DATA_SLOTS_M12 (DATA_SLOTS_M12),
      .DATA_SLOTS_M3  (DATA_SLOTS_M3),
      .ST_SLOTS       (ST_SLOTS),
      .AZ_SLOTS       (AZ_SLOTS)
   ) phase_fsm_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (tick),
      .mode_i      (mode_i),
      .st_en_i     (selftest_en_i),
      .phase_o     (phase),
      .long_slot_o (long_slot)
   );

   proto_seq_st_index #(
      .INTERVAL_SLOTS (ST_INTERVAL_SLOTS),
      .INTERVALS      (ST_INTERVALS),
      .CYCLES         (ST_CYCLES)
   ) st_index_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .active_i   (phase == PH_SELFTEST),
      .tick_i     (tick),
      .cycle_o    (st_cycle_o),
      .interval_o (st_interval_o)
   );

   assign phase_o       = phase;
   assign slot_strobe_o = tick;

   // R2: no slot strobes while initializing
   assert_init_silent_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_o == 3'd0) |-> !slot_strobe_o);

   // R8: indices are zero whenever the phase code is not self-test
   assert_index_outside_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_o != 3'd2 && $past(phase_o) != 3'd2) |-> (st_cycle_o == '0 && st_interval_o == '0));

endmodule

// File: tb/proto_phase_seq_tb_top.sv
module proto_phase_seq_tb_top;

   localparam int INIT    = 40;
   localparam int SHORT   = 5;
   localparam int LONG    = 10;
   localparam int D0      = 3;
   localparam int D12     = 6;
   localparam int D3      = 8;
   localparam int ISLOTS  = 2;
   localparam int NINTV   = 3;
   localparam int NCYC    = 2;
   localparam int AZ      = 7;
   localparam int STAGES  = 2;
   localparam int ST_TOT  = ISLOTS * NINTV * NCYC;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sync_mode = 1'b0;
   logic       sync_in = 1'b0;
   logic [1:0] mode = 2'd0;
   logic       st_en = 1'b0;
   logic [2:0] phase_o;
   logic       strobe_o;
   logic [1:0] cyc_o;
   logic [1:0] intv_o;

   int  total = 0;
   int  bad   = 0;
   bit  done  = 1'b0;

   always #10 clk = ~clk;

   proto_phase_seq #(
      .INIT_CLKS(INIT), .SLOT_CLKS(SHORT), .SLOT_CLKS_LONG(LONG),
      .DATA_SLOTS_M0(D0), .DATA_SLOTS_M12(D12), .DATA_SLOTS_M3(D3),
      .ST_INTERVAL_SLOTS(ISLOTS), .ST_INTERVALS(NINTV), .ST_CYCLES(NCYC),
      .AZ_SLOTS(AZ), .SYNC_STAGES(STAGES)
   ) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .sync_mode_i(sync_mode), .sync_pulse_i(sync_in),
      .mode_i(mode), .selftest_en_i(st_en), .phase_o(phase_o), .slot_strobe_o(strobe_o),
      .st_cycle_o(cyc_o), .st_interval_o(intv_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_ph = 0, m_init = 0, m_div = 0, m_slots = 0, m_mode = 0;
   int m_isl = 0, m_intv = 0, m_cyc = 0;
   bit hist[$];

   function automatic int dlen(input int md);
      return (md == 0) ? D0 : (md == 3) ? D3 : D12;
   endfunction

   function automatic int plen(input int ph);
      case (ph)
         1:       return dlen(m_mode);
         2:       return ST_TOT;
         3:       return AZ;
         default: return 1;
      endcase
   endfunction

   function automatic bit m_tick();
      int n = hist.size();
      bit a = 1'b0;
      bit b = 1'b0;
      if (m_ph == 0) return 1'b0;
      if (sync_mode) begin
         if (n - STAGES >= 0) a = hist[n - STAGES];
         if (n - STAGES - 1 >= 0) b = hist[n - STAGES - 1];
         return a && !b;
      end
      return m_div == (((m_ph == 1) && (m_mode == 0)) ? LONG : SHORT) - 1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_init = 0; m_div = 0; m_slots = 0; m_mode = 0;
         m_isl = 0; m_intv = 0; m_cyc = 0;
         hist.delete();
      end else begin
         bit t;
         t = m_tick();
         hist.push_back(sync_in);
         if (hist.size() > 8) hist.delete(0);
         if (m_ph == 0) begin
            if (m_init == INIT - 1) begin
               m_ph = 1; m_mode = int'(mode); m_div = 0; m_slots = 0;
            end else begin
               m_init++;
            end
         end else begin
            if (!sync_mode) m_div = t ? 0 : m_div + 1;
            if (m_ph == 2 && t) begin
               m_isl++;
               if (m_isl == ISLOTS) begin
                  m_isl = 0;
                  m_intv++;
                  if (m_intv == NINTV) begin
                     m_intv = 0;
                     m_cyc = (m_cyc + 1) % NCYC;
                  end
               end
            end
            if (t && m_ph != 4) begin
               if (m_slots == plen(m_ph) - 1) begin
                  m_slots = 0;
                  case (m_ph)
                     1:       m_ph = st_en ? 2 : 3;
                     2:       m_ph = 3;
                     default: m_ph = 4;
                  endcase
                  m_isl = 0; m_intv = 0; m_cyc = 0;
               end else begin
                  m_slots++;
               end
            end
         end
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         string ptag;
         bit    et;
         case (m_ph)
            0:       ptag = "R11 R2 phase";
            1:       ptag = "R11 R5 phase";
            2:       ptag = "R11 R7 phase";
            3:       ptag = "R11 R9 phase";
            default: ptag = "R11 R10 phase";
         endcase
         et = m_tick();
         chk(int'(phase_o) == m_ph, ptag, int'(phase_o), m_ph);
         chk(strobe_o == et, (m_ph == 0) ? "R2 strobe" : (sync_mode ? "R4 strobe" : "R3 strobe"),
             int'(strobe_o), int'(et));
         chk(int'(cyc_o) == m_cyc && int'(intv_o) == m_intv, "R8 index",
             int'(cyc_o) * 16 + int'(intv_o), m_cyc * 16 + m_intv);
      end
   end

   // ---------------- scenario driver ----------------
   task automatic run_scn(input bit smode, input int md, input bit ste, input int sp_per,
                          input int sp_hi, input int chg_at, input int md_new,
                          input int exp_md, input int tail, input bit chk_rst);
      int ph_cnt[5];
      int sb_cnt[5];
      int normal_seen = 0;
      int cyc = 0;
      int max_c = 0;
      int max_i = 0;
      foreach (ph_cnt[k]) begin
         ph_cnt[k] = 0;
         sb_cnt[k] = 0;
      end
      rst_n = 1'b0; sync_mode = smode; mode = 2'(md); st_en = ste; sync_in = 1'b0;
      repeat (3) @(negedge clk);
      if (chk_rst) begin
         // R1: reset values
         chk(phase_o == 3'd0, "R1 phase", int'(phase_o), 0);
         chk(strobe_o == 1'b0, "R1 strobe", int'(strobe_o), 0);
         chk(cyc_o == 2'd0 && intv_o == 2'd0, "R1 index", int'(cyc_o) + int'(intv_o), 0);
      end
      rst_n = 1'b1;
      while (normal_seen < tail && cyc < 20000) begin
         int p;
         sync_in = (sp_per > 0) && ((cyc % sp_per) < sp_hi);
         if (cyc == chg_at) mode = 2'(md_new);
         p = int'(phase_o);
         if (p < 5) begin
            ph_cnt[p]++;
            sb_cnt[p] += int'(strobe_o);
         end
         if (p == 4) normal_seen++;
         if (int'(cyc_o) > max_c) max_c = int'(cyc_o);
         if (int'(intv_o) > max_i) max_i = int'(intv_o);
         @(posedge clk);
         @(negedge clk);
         cyc++;
      end
      chk(normal_seen == tail, "R10 reached normal", normal_seen, tail);
      chk(ph_cnt[0] == INIT, "R2 init length", ph_cnt[0], INIT);
      chk(sb_cnt[0] == 0, "R2 init strobes", sb_cnt[0], 0);
      if (!smode) begin
         chk(ph_cnt[1] == dlen(exp_md) * ((exp_md == 0) ? LONG : SHORT), "R5 R6 R3 data cycles",
             ph_cnt[1], dlen(exp_md) * ((exp_md == 0) ? LONG : SHORT));
         chk(ph_cnt[2] == (ste ? ST_TOT * SHORT : 0), "R7 selftest cycles", ph_cnt[2],
             ste ? ST_TOT * SHORT : 0);
         chk(ph_cnt[3] == AZ * SHORT, "R9 autozero cycles", ph_cnt[3], AZ * SHORT);
         chk(sb_cnt[4] == tail / SHORT, "R10 normal strobes", sb_cnt[4], tail / SHORT);
      end else begin
         chk(sb_cnt[1] == dlen(exp_md), "R4 R5 data strobes", sb_cnt[1], dlen(exp_md));
         chk(sb_cnt[2] == (ste ? ST_TOT : 0), "R7 selftest strobes", sb_cnt[2], ste ? ST_TOT : 0);
         chk(sb_cnt[3] == AZ, "R9 autozero strobes", sb_cnt[3], AZ);
      end
      if (ste) begin
         chk(max_c == NCYC - 1, "R8 max cycle index", max_c, NCYC - 1);
         chk(max_i == NINTV - 1, "R8 max interval index", max_i, NINTV - 1);
      end
   endtask

   initial begin
      // async, mode 0 (long slots), self-test on, pulses present but ignored
      run_scn(1'b0, 0, 1'b1, 7, 1, -1, 0, 0, 30, 1'b1);
      // async, mode 3, self-test skipped, mode field changed mid data (R6)
      run_scn(1'b0, 3, 1'b0, 0, 0, INIT + 5, 0, 3, 30, 1'b0);
      // async, mode changed in the last init cycle: the new value is captured (R6)
      run_scn(1'b0, 2, 1'b1, 0, 0, INIT - 1, 0, 0, 30, 1'b0);
      // sync, mode 1, narrow pulses, also during init (R2, R4)
      run_scn(1'b1, 1, 1'b1, 4, 1, -1, 0, 1, 20, 1'b1);
      // sync, mode 0, wide held pulses, self-test off (R4)
      run_scn(1'b1, 0, 1'b0, 6, 3, -1, 0, 0, 20, 1'b0);
      // async, mode 2, self-test on
      run_scn(1'b0, 2, 1'b1, 0, 0, -1, 0, 2, 30, 1'b0);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule